// File: doc/BRIEF.md
# Debug Session Arm and Breakpoint Control

This block holds the control register of an on-chip debug unit and runs the life of one debug session. Software arms the unit through a byte-wide register port. Arming restarts an external state sequencer from its first state. The session then ends in one of four ways: the sequencer reports its final state, software forces an immediate trigger, software writes the abort combination, or software disarms the unit. When trace capture is enabled, the breakpoint that ends the session is held back until the trace unit reports that capture is complete.

A breakpoint leaves the block as a one-cycle pulse on one of two outputs: a background-debug request or a software-interrupt request. The choice depends on a target bit and on whether background debug is enabled. The same register carries a two-bit bank select. This select picks which comparator bank answers in an eight-byte window of the address map, and which of four status bytes answers at a single status address. The comparators, the sequencer's transitions and the trace memory sit outside this block.

Top module: `dbg_session_ctrl`

## Requirements
- R1: After reset, `armed` is 0, every pulse output is 0, and the control register at address 0x0 reads 0x00.
- R2: The control register layout is: bit 0 arm, bit 1 trigger, bit 2 breakpoint enable, bit 3 target (1 = prefer background debug), bits 5:4 bank select. All other bits read 0. The trigger bit always reads 0. A write with the trigger bit at 0 stores all the other fields as written.
- R3: A write that sets the arm bit while the unit is disarmed produces a one-cycle `seq_enter` pulse in the cycle after the write. A write with the trigger bit at 0 never produces `trig_pulse`.
- R4: A write with both arm and trigger at 0 disarms the unit and discards any breakpoint that is waiting for trace completion.
- R5: While the unit is armed, a write with trigger 1 and arm 0 leaves the arm bit unchanged by the write and produces a one-cycle `trig_pulse` in the following cycle. The trigger then counts as reaching the final state.
- R6: A write with both trigger and arm at 1 ends the session. `armed` reads 0 in the next cycle, no breakpoint is issued, no `trig_pulse` is produced, and a waiting breakpoint is discarded.
- R7: While `secure` is 1, a trigger write produces no `trig_pulse` and no breakpoint, and the unit stays armed. Tracing is also treated as disabled, so a final-state event breaks at once.
- R8: While `trace_active` is 1, a trigger write has no effect: there is no `trig_pulse` and the unit stays armed.
- R9: A `final_state` pulse while armed with tracing disabled ends the session. `armed` is 0 in the next cycle and the breakpoint, if enabled, appears in that same cycle. A `final_state` pulse while disarmed does nothing.
- R10: With tracing enabled, reaching the final state keeps `armed` at 1 and withholds the breakpoint. The breakpoint and the disarm then happen in the cycle after a `trace_done` pulse.
- R11: The breakpoint destination is chosen as follows. Target 1 with `bdm_en` 1 gives `bdm_req`. Target 1 with `bdm_en` 0 gives `swi_req`. Target 0 with `bdm_en` 0 gives `swi_req`. Target 0 with `bdm_en` 1 gives no request, although the session still ends. With breakpoint enable at 0, no request is issued.
- R12: `bdm_req` and `swi_req` are never high together, and each is high for exactly one cycle per breakpoint.
- R13: Addresses 0x8 to 0xF form the window. For banks 0, 1 and 2, a write raises only bit `bank` of `win_we`, `win_off` carries address bits 2:0, and a read returns byte `bank` of `bank_rdata`. With bank select 3, window reads return 0 and writes raise no strobe.
- R14: A read at address 0x7 returns byte `bank` of `stat_rdata`, for all four bank codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| final_state | input | 1 | Sequencer reached its final state (pulse) |
| trace_en | input | 1 | Trace capture enabled |
| trace_active | input | 1 | Trace already running with begin alignment |
| trace_done | input | 1 | Trace capture completed (pulse) |
| secure | input | 1 | Secure mode: trace and trigger suppressed |
| bdm_en | input | 1 | Background debug enabled |
| bank_rdata | input | 24 | Byte at `win_off` from each of the three banks |
| stat_rdata | input | 32 | Four status bytes, byte n selected by bank code n |
| seq_enter | output | 1 | Force sequencer into its first state (pulse) |
| trig_pulse | output | 1 | Immediate trigger request (pulse) |
| bdm_req | output | 1 | Breakpoint to background debug (pulse) |
| swi_req | output | 1 | Breakpoint to software interrupt (pulse) |
| armed | output | 1 | Current arm bit |
| win_we | output | 3 | Per-bank window write strobe |
| win_off | output | 3 | Byte offset inside the window |

## Verification
The hardest situation to reach is a session that has hit its final state and is parked waiting for trace completion. It is then ended some other way: by the abort write, by a plain disarm, or by a late `trace_done` that must no longer produce a breakpoint. The bench reaches this state by arming with tracing enabled, pulsing `final_state`, and checking that `armed` stays high with no request. It then applies the competing write and pulses `trace_done` afterwards to show that nothing escapes. Secure mode is driven the same way, to show that the same final-state event now breaks at once.

// File: rtl/dbg_sess_pkg.sv
package dbg_sess_pkg;

    localparam int CTRL_W  = 8;
    localparam int BANK_W  = 2;
    localparam int BYTE_W  = 8;
    localparam int NBANK   = (1 << BANK_W) - 1;
    localparam int NSTAT   = 1 << BANK_W;

    localparam int B_ARM   = 0;
    localparam int B_TRIG  = 1;
    localparam int B_BRKEN = 2;
    localparam int B_TGT   = 3;
    localparam int B_BANK  = 4;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              tgt;
        logic              brk_en;
        logic              arm;
    } ctrl_t;

    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_SWI  = 2'd1,
        DEST_BDM  = 2'd2
    } brk_dest_e;

    function automatic brk_dest_e pick_dest(input logic tgt, input logic bdm_en);
        if (!bdm_en)
            return DEST_SWI;
        return tgt ? DEST_BDM : DEST_NONE;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
        logic [CTRL_W-1:0] r;
        r                    = '0;
        r[B_ARM]             = c.arm;
        r[B_BRKEN]           = c.brk_en;
        r[B_TGT]             = c.tgt;
        r[B_BANK +: BANK_W]  = c.bank;
        return r;
    endfunction

endpackage

// File: rtl/dbg_sess_fsm.sv
module dbg_sess_fsm
    import dbg_sess_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              final_state,
    input  logic              trace_en,
    input  logic              trace_active,
    input  logic              trace_done,
    input  logic              secure,
    output ctrl_t             ctrl_q,
    output logic              seq_enter,
    output logic              trig_pulse,
    output logic              end_evt
);

    logic w_arm, w_trig, kill, trig_ok, tracing, fire, pending_q;

    assign w_arm   = wdata[B_ARM];
    assign w_trig  = wdata[B_TRIG];
    assign kill    = ctrl_wr & w_arm & w_trig;
    assign tracing = trace_en & ~secure;
    assign trig_ok = ctrl_wr & w_trig & ~w_arm & ctrl_q.arm & ~pending_q
                   & ~secure & ~trace_active;
    assign fire    = trig_ok | (~ctrl_wr & ctrl_q.arm & ~pending_q & final_state);
    assign end_evt = (fire & ~tracing) | (~ctrl_wr & pending_q & trace_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            pending_q  <= 1'b0;
            seq_enter  <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            seq_enter  <= 1'b0;
            trig_pulse <= trig_ok;
            if (ctrl_wr) begin
                ctrl_q.bank   <= wdata[B_BANK +: BANK_W];
                ctrl_q.tgt    <= wdata[B_TGT];
                ctrl_q.brk_en <= wdata[B_BRKEN];
                if (kill) begin
                    ctrl_q.arm <= 1'b0;
                    pending_q  <= 1'b0;
                end else if (!w_trig) begin
                    ctrl_q.arm <= w_arm;
                    seq_enter  <= w_arm & ~ctrl_q.arm;
                    if (!w_arm)
                        pending_q <= 1'b0;
                end
            end
            if (end_evt) begin
                ctrl_q.arm <= 1'b0;
                pending_q  <= 1'b0;
            end else if (fire && tracing) begin
                pending_q  <= 1'b1;
            end
        end
    end

    assert_start_armed_R3: assert property (@(posedge clk) disable iff (rst)
        seq_enter |-> ctrl_q.arm);
    assert_trig_secure_R7: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> !$past(secure));
    assert_trig_busy_R8: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> !$past(trace_active));
    assert_hold_armed_R10: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> ctrl_q.arm);
    assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!ctrl_q.arm && !trig_pulse));

endmodule

// File: rtl/dbg_brk_route.sv
module dbg_brk_route
    import dbg_sess_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic tgt,
    input  logic bdm_en,
    output logic bdm_req,
    output logic swi_req
);

    brk_dest_e dest;

    assign dest = pick_dest(tgt, bdm_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            bdm_req <= 1'b0;
            swi_req <= 1'b0;
        end else begin
            bdm_req <= go && (dest == DEST_BDM);
            swi_req <= go && (dest == DEST_SWI);
        end
    end

    assert_one_dest_R12: assert property (@(posedge clk) disable iff (rst)
        !(bdm_req && swi_req));
    assert_bdm_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        bdm_req |=> !bdm_req);
    assert_swi_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        swi_req |=> !swi_req);
    assert_no_bdm_off_R11: assert property (@(posedge clk) disable iff (rst)
        bdm_req |-> $past(bdm_en));

endmodule

// File: rtl/dbg_bank_dec.sv
module dbg_bank_dec
    import dbg_sess_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 7,
    parameter int WIN_BASE  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [BANK_W-1:0]         bank,
    input  logic [NBANK*BYTE_W-1:0]   bank_rdata,
    input  logic [NSTAT*BYTE_W-1:0]   stat_rdata,
    output logic [NBANK-1:0]          win_we,
    output logic [2:0]                win_off,
    output logic                      hit,
    output logic [BYTE_W-1:0]         rd_data
);

    localparam int OFF_W = 3;
    localparam logic [ADDR_W-1:0] WIN_V  = WIN_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] STAT_V = STAT_ADDR[ADDR_W-1:0];

    logic win_hit, stat_hit, bank_ok;

    assign win_hit  = reg_addr[ADDR_W-1:OFF_W] == WIN_V[ADDR_W-1:OFF_W];
    assign stat_hit = reg_addr == STAT_V;
    assign bank_ok  = int'(bank) < NBANK;
    assign win_off  = reg_addr[OFF_W-1:0];
    assign hit      = win_hit | stat_hit;

    for (genvar g = 0; g < NBANK; g++) begin : g_we
        assign win_we[g] = reg_wr & win_hit & (int'(bank) == g);
    end

    always_comb begin
        rd_data = '0;
        if (win_hit && bank_ok)
            rd_data = bank_rdata[int'(bank)*BYTE_W +: BYTE_W];
        else if (stat_hit)
            rd_data = stat_rdata[int'(bank)*BYTE_W +: BYTE_W];
    end

    assert_dead_bank_R13: assert property (@(posedge clk) disable iff (rst)
        (int'(bank) >= NBANK) |-> (win_we == '0));
    assert_we_onehot_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_we));
    assert_we_needs_wr_R13: assert property (@(posedge clk) disable iff (rst)
        (win_we != '0) |-> reg_wr);

endmodule

// File: rtl/dbg_session_ctrl.sv
module dbg_session_ctrl
    import dbg_sess_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 7,
    parameter int WIN_BASE  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [CTRL_W-1:0]       reg_wdata,
    output logic [CTRL_W-1:0]       reg_rdata,
    input  logic                    final_state,
    input  logic                    trace_en,
    input  logic                    trace_active,
    input  logic                    trace_done,
    input  logic                    secure,
    input  logic                    bdm_en,
    input  logic [NBANK*BYTE_W-1:0] bank_rdata,
    input  logic [NSTAT*BYTE_W-1:0] stat_rdata,
    output logic                    seq_enter,
    output logic                    trig_pulse,
    output logic                    bdm_req,
    output logic                    swi_req,
    output logic                    armed,
    output logic [NBANK-1:0]        win_we,
    output logic [2:0]              win_off
);

    localparam logic [ADDR_W-1:0] CTRL_V = CTRL_ADDR[ADDR_W-1:0];

    ctrl_t             ctrl_q;
    logic              ctrl_hit, ctrl_wr, end_evt, dec_hit;
    logic [BYTE_W-1:0] dec_data;

    assign ctrl_hit = reg_addr == CTRL_V;
    assign ctrl_wr  = reg_wr & ctrl_hit;
    assign armed    = ctrl_q.arm;

    dbg_sess_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .wdata        (reg_wdata),
        .final_state  (final_state),
        .trace_en     (trace_en),
        .trace_active (trace_active),
        .trace_done   (trace_done),
        .secure       (secure),
        .ctrl_q       (ctrl_q),
        .seq_enter    (seq_enter),
        .trig_pulse   (trig_pulse),
        .end_evt      (end_evt)
    );

    dbg_brk_route u_route (
        .clk     (clk),
        .rst     (rst),
        .go      (end_evt & ctrl_q.brk_en),
        .tgt     (ctrl_q.tgt),
        .bdm_en  (bdm_en),
        .bdm_req (bdm_req),
        .swi_req (swi_req)
    );

    dbg_bank_dec #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .WIN_BASE  (WIN_BASE)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .bank       (ctrl_q.bank),
        .bank_rdata (bank_rdata),
        .stat_rdata (stat_rdata),
        .win_we     (win_we),
        .win_off    (win_off),
        .hit        (dec_hit),
        .rd_data    (dec_data)
    );

    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit)
            reg_rdata = pack_ctrl(ctrl_q);
        else if (dec_hit)
            reg_rdata = dec_data;
    end

    assert_disarm_on_brk_R9: assert property (@(posedge clk) disable iff (rst)
        (bdm_req || swi_req) |-> !armed);

    always_comb begin
        if (!rst && ctrl_hit)
            assert_trig_reads_zero_R2: assert (reg_rdata[B_TRIG] == 1'b0);
    end

endmodule

// File: tb/dbg_session_ctrl_tb.sv
module dbg_session_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        final_state = 1'b0, trace_en = 1'b0, trace_active = 1'b0;
    logic        trace_done = 1'b0, secure = 1'b0, bdm_en = 1'b0;
    logic [23:0] bank_rdata = 24'hC3B2A1;
    logic [31:0] stat_rdata = 32'h44332211;
    logic        seq_enter, trig_pulse, bdm_req, swi_req, armed;
    logic [2:0]  win_we, win_off;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    dbg_session_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .final_state(final_state), .trace_en(trace_en),
        .trace_active(trace_active), .trace_done(trace_done),
        .secure(secure), .bdm_en(bdm_en), .bank_rdata(bank_rdata),
        .stat_rdata(stat_rdata), .seq_enter(seq_enter),
        .trig_pulse(trig_pulse), .bdm_req(bdm_req), .swi_req(swi_req),
        .armed(armed), .win_we(win_we), .win_off(win_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fin_pulse();
        @(negedge clk); final_state = 1'b1;
        @(negedge clk); final_state = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); trace_done = 1'b1;
        @(negedge clk); trace_done = 1'b0;
    endtask

    // outputs {armed, bdm_req, swi_req}
    function automatic logic [2:0] obs();
        return {armed, bdm_req, swi_req};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(4'h0, d);
        check("R1 ctrl", d, 8'h00);
        check("R1 outputs", {armed, seq_enter, trig_pulse, bdm_req, swi_req}, 5'b0);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        wr(4'h0, 8'h2C);
        rd(4'h0, d);
        check("R2 readback", d, 8'h2C);
        wr(4'h0, 8'h2E);
        rd(4'h0, d);
        check("R2 trig reads 0", d, 8'h2C);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_arm();
        wr(4'h0, 8'h05);
        check("R3 seq_enter", {seq_enter, trig_pulse, armed}, 3'b101);
        @(negedge clk);
        check("R3 one cycle", seq_enter, 1'b0);
        fin_pulse();
        check("R9 swi break", obs(), 3'b001);
        @(negedge clk);
        check("R12 swi one cycle", obs(), 3'b000);
        fin_pulse();
        check("R9 disarmed ignores final", obs(), 3'b000);
    endtask

    task automatic t_route();
        for (int i = 0; i < 5; i++) begin
            logic [7:0] cfg;
            logic [2:0] exp;
            cfg = (i == 4) ? 8'h09 : (8'h05 | ((i & 1) ? 8'h08 : 8'h00));
            bdm_en = (i >= 2);
            case (i)
                0: exp = 3'b001;
                1: exp = 3'b001;
                2: exp = 3'b000;
                3: exp = 3'b010;
                default: exp = 3'b000;
            endcase
            wr(4'h0, cfg);
            fin_pulse();
            check($sformatf("R11 route case %0d", i), obs(), exp);
            @(negedge clk);
            check($sformatf("R12 pulse ends case %0d", i), obs(), 3'b000);
        end
        bdm_en = 1'b0;
    endtask

    task automatic t_trigger();
        wr(4'h0, 8'h05);
        wr(4'h0, 8'h06);
        check("R5 trig no trace", {trig_pulse, obs()}, 4'b1001);
        trace_en = 1'b1;
        wr(4'h0, 8'h05);
        wr(4'h0, 8'h06);
        check("R5 trig pulse, held", {trig_pulse, obs()}, 4'b1100);
        @(negedge clk);
        check("R5 trig one cycle", trig_pulse, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 still held", obs(), 3'b100);
        done_pulse();
        check("R10 break on trace done", obs(), 3'b001);
        trace_en = 1'b0;
    endtask

    task automatic t_hold_final();
        trace_en = 1'b1;
        wr(4'h0, 8'h05);
        fin_pulse();
        check("R10 final held", obs(), 3'b100);
        wr(4'h0, 8'h07);
        check("R6 abort", {trig_pulse, obs()}, 4'b0000);
        done_pulse();
        check("R6 late done dropped", obs(), 3'b000);
        wr(4'h0, 8'h05);
        fin_pulse();
        wr(4'h0, 8'h04);
        check("R4 disarm", obs(), 3'b000);
        done_pulse();
        check("R4 late done dropped", obs(), 3'b000);
        trace_en = 1'b0;
    endtask

    task automatic t_secure();
        secure = 1'b1;
        wr(4'h0, 8'h05);
        wr(4'h0, 8'h06);
        check("R7 trig blocked", {trig_pulse, obs()}, 4'b0100);
        trace_en = 1'b1;
        fin_pulse();
        check("R7 trace off in secure", obs(), 3'b001);
        secure = 1'b0;
        wr(4'h0, 8'h05);
        trace_active = 1'b1;
        wr(4'h0, 8'h06);
        check("R8 trig ignored while tracing", {trig_pulse, obs()}, 4'b0100);
        trace_active = 1'b0;
        trace_en = 1'b0;
        wr(4'h0, 8'h04);
    endtask

    task automatic t_window();
        logic [7:0] d;
        wr(4'h0, 8'h10);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'hA; reg_wdata = 8'h55;
        #1;
        check("R13 bank1 strobe", {win_we, win_off}, {3'b010, 3'd2});
        @(negedge clk);
        reg_wr = 1'b0;
        rd(4'h9, d);
        check("R13 bank1 read", d, 8'hB2);
        rd(4'h7, d);
        check("R14 status bank1", d, 8'h22);
        wr(4'h0, 8'h30);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'hC;
        #1;
        check("R13 bank3 no strobe", win_we, 3'b000);
        @(negedge clk);
        reg_wr = 1'b0;
        rd(4'hC, d);
        check("R13 bank3 reads 0", d, 8'h00);
        rd(4'h7, d);
        check("R14 status bank3", d, 8'h44);
        wr(4'h0, 8'h00);
        rd(4'h7, d);
        check("R14 status bank0", d, 8'h11);
        rd(4'h8, d);
        check("R13 bank0 read", d, 8'hA1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_arm();
        t_route();
        t_trigger();
        t_hold_final();
        t_secure();
        t_window();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule